// File: doc/BRIEF.md
# MDIO Management Access Engine

This block lets a processor run one clause-22 management transaction on the MDC/MDIO pins of an Ethernet PHY through a single 32-bit access word. Software writes the word with the request flag set. The word also carries the direction, the PHY address, the PHY register address and, for a write, the 16-bit value. The engine builds the serial frame and shifts it out. It then clears the request flag in the same word. Software polls that flag to learn that the transaction has finished.

When a read completes, the 16 bits returned by the PHY replace the low half of the word. All other fields keep the values that software wrote. While a transaction is in flight, the word is locked, and bus writes to it are dropped. MDC runs only during a transaction. Each half period of MDC lasts a parameterised number of system clock cycles.

Top module: `mdio_access_engine`

## Requirements
- R1: After reset the access word reads 0, MDC is low and the MDIO output enable is low.
- R2: A bus write while the request flag (bit 31) is clear loads the whole word. If the written bit 31 is 0, no transaction starts and MDC stays low.
- R3: A write with bit 31 set starts a transaction. Bit 31 reads back 1 until the transaction ends and 0 afterwards. After a write transaction (bit 30 = 1) bits 30:0 are unchanged.
- R4: The word is decoded as: bit 30 = 1 for write and 0 for read, bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. For example, a write of 0x9000 to register 0 of PHY 5 is 0xC0A09000.
- R5: A write frame is 64 bits, sent MSB first with the output enabled for every bit: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then 16 data bits.
- R6: A read frame drives 32 ones, 01, opcode 10, PHY address and register address (46 bits). It then releases MDIO for the two turnaround bits and the 16 data bits.
- R7: In a read, the 16 bits sampled on MDC rising edges after the turnaround are placed in bits 15:0, first bit received in bit 15. Bits 30:16 keep their written values.
- R8: MDC has a period of 2*HALF_DIV system clocks. A transaction gives exactly 64 MDC rising edges. MDIO output changes only while MDC is low.
- R9: A bus write while bit 31 is set is ignored. It does not change the word or the frame in flight.
- R10: Outside a transaction MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the access word |
| reg_wdata_i | input | 32 | Write data for the access word |
| reg_rdata_o | output | 32 | Current access word |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
The bench sweeps every PHY address in both directions. For each address it varies the register address and data patterns, so a swapped, shifted or truncated field shows up as a wrong bit at a known frame position. Read transactions return a different pattern per address from a PHY model. This separates a correct capture from an off-by-one sample position, a reversed bit order and a clobbered high half. A write issued mid-transaction, a plain load with the request flag clear, and the stated encoding example cover locking, the idle path and the field layout. MDC period and the count of rising edges are measured on every transaction.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned PRE_W   = 32;
  localparam int unsigned FRAME_W = PRE_W + 2 + 2 + 2*ADDR_W + 2 + DATA_W;
  localparam int unsigned TA_POS  = PRE_W + 4 + 2*ADDR_W;
  localparam int unsigned DAT_POS = TA_POS + 2;
  localparam int unsigned BIDX_W  = $clog2(FRAME_W);

  typedef struct packed {
    logic              req;
    logic              wr;
    logic [3:0]        rsvd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] rg;
    logic [DATA_W-1:0] data;
  } acc_word_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = en_i & wrap & ~mdc_q;
  assign fall_o = en_i & wrap & mdc_q;

  // R10
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_eng_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  acc_word_t         word_i,
  input  logic              en_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [FRAME_W-1:0] tx_sr_q;
  logic [BIDX_W-1:0]  bidx_q;
  logic               is_rd_q;
  logic [DATA_W-1:0]  rx_sr_q;
  logic [FRAME_W-1:0] frame;

  always_comb begin
    frame = {{PRE_W{1'b1}}, 2'b01,
             (word_i.wr ? 2'b01 : 2'b10),
             word_i.phy, word_i.rg,
             (word_i.wr ? 2'b10 : 2'b11),
             (word_i.wr ? word_i.data : {DATA_W{1'b1}})};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q <= '1;
      bidx_q  <= '0;
      is_rd_q <= 1'b0;
    end else if (start_i) begin
      tx_sr_q <= frame;
      bidx_q  <= '0;
      is_rd_q <= ~word_i.wr;
    end else if (en_i && fall_i) begin
      tx_sr_q <= {tx_sr_q[FRAME_W-2:0], 1'b1};
      bidx_q  <= bidx_q + BIDX_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr_q <= '0;
    end else if (en_i && rise_i && is_rd_q && bidx_q >= BIDX_W'(DAT_POS)) begin
      rx_sr_q <= {rx_sr_q[DATA_W-2:0], mdio_i};
    end
  end

  assign mdio_o    = tx_sr_q[FRAME_W-1];
  assign mdio_oe_o = en_i & (~is_rd_q | (bidx_q < BIDX_W'(TA_POS)));
  assign done_o    = en_i & fall_i & (bidx_q == BIDX_W'(FRAME_W - 1));
  assign rd_data_o = rx_sr_q;

  // R8
  mdio_change_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !start_i) |=> $stable(mdio_o));

  // R6
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && is_rd_q && rise_i && bidx_q >= BIDX_W'(TA_POS)) |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_access_engine.sv
module mdio_access_engine
  import mdio_eng_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  acc_word_t         word_q;
  acc_word_t         wr_word;
  logic              accept;
  logic              start;
  logic              busy;
  logic              rise;
  logic              fall;
  logic              done;
  logic [DATA_W-1:0] rd_data;

  assign wr_word = acc_word_t'(reg_wdata_i);
  assign busy    = word_q.req;
  assign accept  = reg_we_i & ~busy;
  assign start   = accept & wr_word.req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (accept) begin
      word_q <= wr_word;
    end else if (done) begin
      word_q.req <= 1'b0;
      if (!word_q.wr) word_q.data <= rd_data;
    end
  end

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .word_i    (wr_word),
    .en_i      (busy),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .rd_data_o (rd_data)
  );

  assign reg_rdata_o = word_q;

  // R3
  req_clear_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(word_q.req) |-> $past(done));

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> $stable(word_q));

  // R10
  oe_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> busy);

  // R3
  write_keeps_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && word_q.wr) |=> (word_q[WORD_W-2:0] == $past(word_q[WORD_W-2:0])));
endmodule

// File: tb/tb_mdio_access_engine.sv
`timescale 1ns/1ps
module tb_mdio_access_engine;
  localparam int HALF = 2;
  localparam int TCLK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int total = 0;
  int bad = 0;

  logic        cap_bit [64];
  logic        cap_oe  [64];
  int          n_rise = 0;
  int          per_err = 0;
  time         last_rise = 0;
  logic [15:0] rd_val = 16'h0;

  always #(TCLK/2) clk = ~clk;

  mdio_access_engine #(.HALF_DIV(HALF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_out),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // PHY model
  always @(posedge mdc) begin
    if (n_rise < 64) begin
      cap_bit[n_rise] = mdio_out;
      cap_oe[n_rise]  = mdio_oe;
    end
    if (n_rise > 0 && ($time - last_rise) != time'(2*HALF*TCLK)) per_err++;
    last_rise = $time;
    n_rise++;
  end

  always @(negedge mdc) begin
    if (n_rise >= 48 && n_rise <= 63) mdio_in = rd_val[63-n_rise];
    else mdio_in = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] build_frame(input logic [31:0] w);
    return {32'hFFFF_FFFF, 2'b01, (w[30] ? 2'b01 : 2'b10), w[25:21], w[20:16],
            2'b10, w[15:0]};
  endfunction

  task automatic wr_bus(input logic [31:0] w);
    @(negedge clk); we = 1'b1; wdata = w;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_idle(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (!rdata[31]) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_txn(input logic [31:0] w, input logic [15:0] phy_val, input bit poke);
    bit ok;
    logic [63:0] fr, got;
    bit fr_ok;
    logic [31:0] exp_w;
    n_rise = 0; per_err = 0; rd_val = phy_val;
    wr_bus(w);
    check(rdata[31] == 1'b1, "R3", {32'h0, rdata}, {32'h0, w});
    if (poke) begin
      repeat (20) @(negedge clk);
      wr_bus(~w);
      check(rdata == w, "R9", {32'h0, rdata}, {32'h0, w});
    end
    wait_idle(ok);
    check(ok, "R3", 64'(ok), 64'd1);
    fr = build_frame(w);
    fr_ok = 1'b1;
    got = '0;
    for (int i = 0; i < 64; i++) begin
      got[63-i] = cap_bit[i];
      if (w[30] || i < 46) begin
        if (cap_oe[i] !== 1'b1 || cap_bit[i] !== fr[63-i]) fr_ok = 1'b0;
      end else if (cap_oe[i] !== 1'b0) fr_ok = 1'b0;
    end
    check(fr_ok, w[30] ? "R5" : "R6", got, fr);
    check(n_rise == 64 && per_err == 0, "R8", 64'(n_rise), 64'd64);
    exp_w = w[30] ? {1'b0, w[30:0]} : {1'b0, w[30:16], phy_val};
    check(rdata == exp_w, w[30] ? "R3" : "R7", {32'h0, rdata}, {32'h0, exp_w});
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R10", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  initial begin
    #(200000*TCLK);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdata == 32'h0 && mdc == 1'b0 && mdio_oe == 1'b0, "R1",
          {31'h0, mdc, rdata}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: plain load, no transaction
    n_rise = 0;
    wr_bus(32'h4ABC_1234);
    repeat (40) @(negedge clk);
    check(rdata == 32'h4ABC_1234, "R2", {32'h0, rdata}, 64'h4ABC_1234);
    check(n_rise == 0 && mdc == 1'b0, "R2", 64'(n_rise), 64'h0);

    // R4: stated encodings
    run_txn(32'hC0A0_9000, 16'h0, 1'b0);
    check(cap_bit[36] == 1'b0 && cap_bit[38] == 1'b1 && cap_bit[40] == 1'b1,
          "R4", {61'h0, cap_bit[36], cap_bit[38], cap_bit[40]}, 64'h3);
    run_txn(32'hC0C0_9000, 16'h0, 1'b0);

    // R9: write while busy
    run_txn(32'hC0A5_5AA5, 16'h0, 1'b1);
    run_txn(32'h80C3_0000, 16'hBEEF, 1'b1);

    for (int p = 0; p < 32; p++) begin
      logic [4:0]  rg  = 5'(31 - p);
      logic [15:0] dat = 16'((p * 16'h1357) ^ 16'hA5C3);
      run_txn({2'b11, 4'h0, 5'(p), rg, dat}, 16'h0, 1'b0);
      run_txn({2'b10, 4'h0, 5'(p), 5'(p*7), 16'hFFFF}, 16'((p * 16'h2B1D) ^ 16'h8001), 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule